// File: doc/BRIEF.md
# Asynchronous Bus Write-Cycle Sequencer

This block is the bus-master side of a 16-bit asynchronous bus for write transfers only. A requester hands it one write: an address, a data word, a function code and a two-bit byte-lane mask. The block then steps through eight half-bus-clock phases, S0 to S7. One cycle of `clk_i` is one half-clock phase. In each phase it drives the function-code lines, the address bus, the address strobe, the upper and lower data strobes, the read/write line and the output enables of the address and data buses.

The slave ends the transfer with an active-low acknowledge or an active-low bus error. Both inputs are asynchronous, so each passes through a two-flop synchronizer before the sequencer looks at it. If neither has arrived when S4 ends, the block adds wait states until one does. Each wait state is a whole bus clock, which is two `clk_i` cycles. When the transfer finishes, the block gives the requester a one-cycle completion pulse or a one-cycle error pulse.

Top module: `wrc_write_seq`

## Requirements
- R1: After reset, and in every idle cycle, the outputs hold these values: `busy_o` low, `as_no`, `uds_no` and `lds_no` high, `rw_o` high, both output enables low, `done_o` and `err_o` low. The function-code, address and data outputs read zero whenever they are not enabled.
- R2: A request with a nonzero lane mask, sampled in an idle cycle, starts S0 in the next cycle. `busy_o` then stays high from S0 through S7, including wait states. `fc_o` carries the request's function code for the whole cycle, and `rw_o` is high in S0 and S1. A request with lane mask 00 starts nothing.
- R3: `addr_oe_o` is high from S1 through S7, and `addr_o` holds the captured address over that span.
- R4: `as_no` is low from S2 through S6, including wait states, and high again in S7. `rw_o` is low from S2 through S7.
- R5: `data_oe_o` is high from S3 through S7, including wait states, and `data_o` carries the captured write data.
- R6: `uds_no` (lane bit 1) and `lds_no` (lane bit 0) are low only in S4, S5, S6 and wait states, and only for a lane set in the mask.
- R7: Acknowledge and bus error are each synchronized by two flops. The sequencer samples them at the end of S4 and at the end of each wait state, and each wait state lasts two `clk_i` cycles. Suppose a terminating input goes active at the edge that ends the D-th cycle after the first cycle with `as_no` low, counting from 0. Then the transfer has ceil(D/2) wait states and lasts 8 + 2*ceil(D/2) cycles.
- R8: In the cycle after S7, `done_o` is high for exactly one cycle when the transfer ended by acknowledge.
- R9: A transfer ended by bus error raises `err_o` for one cycle in place of `done_o`. When both inputs are active at once, the bus error takes precedence.
- R10: A request while `busy_o` is high is ignored. The captured function code, address, data and lanes stay on the bus, and no second transfer follows.
- R11: In the cycle after S7, both enables are low and `rw_o` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one cycle per half bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Write request, sampled while idle |
| addr_i | input | AW | Word address of the write |
| wdata_i | input | DW | Write data |
| fc_i | input | FCW | Function code for the transfer |
| be_i | input | 2 | Lane mask: bit 1 upper, bit 0 lower |
| ack_ni | input | 1 | Asynchronous acknowledge, active low |
| berr_ni | input | 1 | Asynchronous bus error, active low |
| busy_o | output | 1 | Transfer in progress, S0 to S7 |
| done_o | output | 1 | One-cycle pulse on normal completion |
| err_o | output | 1 | One-cycle pulse on bus-error completion |
| fc_o | output | FCW | Function-code lines |
| addr_o | output | AW | Address bus value |
| addr_oe_o | output | 1 | Address bus drive enable |
| data_o | output | DW | Data bus value |
| data_oe_o | output | 1 | Data bus drive enable |
| as_no | output | 1 | Address strobe, active low |
| uds_no | output | 1 | Upper data strobe, active low |
| lds_no | output | 1 | Lower data strobe, active low |
| rw_o | output | 1 | Read/write, low for write |

## Verification
The hardest case to reach is the exact boundary where a terminating input reaches the sequencer just in time for one sample point, or one cycle too late for it. That boundary sits behind two synchronizer flops and a sampling grid two cycles wide. The stimulus plays a slave that counts cycles from the first cycle with the address strobe low and asserts its response after a chosen delay D. Directed values of D, both even and odd, land on each side of a sample point, and random values of D cover the rest. The expected number of wait states follows from D alone. Bus-error and simultaneous-response runs, and requests injected while busy, reuse the same slave.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

    // Sequencer phases: IDLE, the eight half-clock states, and the two
    // halves of one wait state.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S0,
        ST_S1,
        ST_S2,
        ST_S3,
        ST_S4,
        ST_S5,
        ST_S6,
        ST_S7,
        ST_WA,
        ST_WB
    } wrc_state_e;

    // Control lines driven onto the bus, one value per phase.
    typedef struct packed {
        logic busy;
        logic addr_oe;
        logic data_oe;
        logic as_n;
        logic rw;
        logic uds_n;
        logic lds_n;
    } wrc_ctl_t;

    localparam wrc_ctl_t CTL_IDLE = '{
        busy:    1'b0,
        addr_oe: 1'b0,
        data_oe: 1'b0,
        as_n:    1'b1,
        rw:      1'b1,
        uds_n:   1'b1,
        lds_n:   1'b1
    };

    // Maps a phase and a lane mask to the bus control levels for that phase.
    function automatic wrc_ctl_t wrc_decode(input wrc_state_e st, input logic [1:0] lanes);
        wrc_ctl_t c;
        logic     strobe_ph;
        logic     as_ph;
        c         = CTL_IDLE;
        strobe_ph = (st == ST_S4) || (st == ST_S5) || (st == ST_S6) ||
                    (st == ST_WA) || (st == ST_WB);
        as_ph     = strobe_ph || (st == ST_S2) || (st == ST_S3);
        c.busy    = (st != ST_IDLE);
        c.addr_oe = c.busy && (st != ST_S0);
        c.rw      = !(as_ph || (st == ST_S7));
        c.as_n    = !as_ph;
        c.data_oe = strobe_ph || (st == ST_S3) || (st == ST_S7);
        c.uds_n   = !(strobe_ph && lanes[1]);
        c.lds_n   = !(strobe_ph && lanes[0]);
        return c;
    endfunction

endpackage

// File: rtl/wrc_sync.sv
module wrc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[LAST];

endmodule

// File: rtl/wrc_seq_fsm.sv
module wrc_seq_fsm
    import wrc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       req_i,
    input  logic [1:0] lanes_i,
    input  logic       ack_s_i,
    input  logic       berr_s_i,
    output wrc_state_e state_d_o,
    output logic       load_o,
    output logic       done_o,
    output logic       err_o
);

    typedef struct packed {
        wrc_state_e st;
        logic       berr_seen;
        logic       done;
        logic       err;
    } fsm_t;

    localparam fsm_t FSM_RST = '{st: ST_IDLE, berr_seen: 1'b0, done: 1'b0, err: 1'b0};

    fsm_t fsm_d, fsm_q;
    logic load_d;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        fsm_d.err  = 1'b0;
        load_d     = 1'b0;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (req_i && (lanes_i != 2'b00)) begin
                    fsm_d.st        = ST_S0;
                    fsm_d.berr_seen = 1'b0;
                    load_d          = 1'b1;
                end
            end
            ST_S0: fsm_d.st = ST_S1;
            ST_S1: fsm_d.st = ST_S2;
            ST_S2: fsm_d.st = ST_S3;
            ST_S3: fsm_d.st = ST_S4;
            ST_S4, ST_WB: begin
                if (berr_s_i) begin
                    fsm_d.berr_seen = 1'b1;
                    fsm_d.st        = ST_S5;
                end else if (ack_s_i) begin
                    fsm_d.st = ST_S5;
                end else begin
                    fsm_d.st = ST_WA;
                end
            end
            ST_WA: fsm_d.st = ST_WB;
            ST_S5: fsm_d.st = ST_S6;
            ST_S6: fsm_d.st = ST_S7;
            ST_S7: begin
                fsm_d.st   = ST_IDLE;
                fsm_d.done = !fsm_q.berr_seen;
                fsm_d.err  = fsm_q.berr_seen;
            end
            default: fsm_d = FSM_RST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fsm_q <= FSM_RST;
        else         fsm_q <= fsm_d;
    end

    assign state_d_o = fsm_d.st;
    assign load_o    = load_d;
    assign done_o    = fsm_q.done;
    assign err_o     = fsm_q.err;

    // R8
    done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && err_o));

    // R8
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    wait_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.st == ST_S5) |-> ($past(ack_s_i) || $past(berr_s_i)));

endmodule

// File: rtl/wrc_bus_drv.sv
module wrc_bus_drv
    import wrc_pkg::*;
#(
    parameter int AW  = 23,
    parameter int DW  = 16,
    parameter int FCW = 3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           load_i,
    input  wrc_state_e     state_d_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  data_i,
    input  logic [FCW-1:0] fc_i,
    input  logic [1:0]     lanes_i,
    output wrc_ctl_t       ctl_o,
    output logic [FCW-1:0] fc_o,
    output logic [AW-1:0]  addr_o,
    output logic [DW-1:0]  data_o
);

    typedef struct packed {
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        logic [FCW-1:0] fc;
        logic [1:0]     lanes;
        wrc_ctl_t       ctl;
    } drv_t;

    drv_t drv_d, drv_q;

    always_comb begin
        drv_d = drv_q;
        if (load_i) begin
            drv_d.addr  = addr_i;
            drv_d.data  = data_i;
            drv_d.fc    = fc_i;
            drv_d.lanes = lanes_i;
        end
        drv_d.ctl = wrc_decode(state_d_i, drv_d.lanes);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            drv_q       <= '0;
            drv_q.ctl   <= CTL_IDLE;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign ctl_o  = drv_q.ctl;
    assign fc_o   = drv_q.ctl.busy    ? drv_q.fc   : '0;
    assign addr_o = drv_q.ctl.addr_oe ? drv_q.addr : '0;
    assign data_o = drv_q.ctl.data_oe ? drv_q.data : '0;

    // R4
    as_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctl_o.as_n |-> !ctl_o.rw);

    // R6
    strobe_in_as_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctl_o.uds_n || !ctl_o.lds_n) |-> (!ctl_o.as_n && ctl_o.data_oe));

    // R5
    data_within_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_o.data_oe |-> ctl_o.addr_oe);

    // R10
    addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_o.addr_oe && $past(ctl_o.addr_oe)) |-> $stable(addr_o));

    // R2
    fc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_o.busy && $past(ctl_o.busy)) |-> $stable(fc_o));

endmodule

// File: rtl/wrc_write_seq.sv
module wrc_write_seq
    import wrc_pkg::*;
#(
    parameter int AW          = 23,
    parameter int DW          = 16,
    parameter int FCW         = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           req_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic [FCW-1:0] fc_i,
    input  logic [1:0]     be_i,
    input  logic           ack_ni,
    input  logic           berr_ni,
    output logic           busy_o,
    output logic           done_o,
    output logic           err_o,
    output logic [FCW-1:0] fc_o,
    output logic [AW-1:0]  addr_o,
    output logic           addr_oe_o,
    output logic [DW-1:0]  data_o,
    output logic           data_oe_o,
    output logic           as_no,
    output logic           uds_no,
    output logic           lds_no,
    output logic           rw_o
);

    localparam int TERM_W = 2;

    logic [TERM_W-1:0] term_raw;
    logic [TERM_W-1:0] term_sync;
    wrc_state_e        state_d;
    logic              load;
    wrc_ctl_t          ctl;

    assign term_raw = {~berr_ni, ~ack_ni};

    wrc_sync #(
        .WIDTH  (TERM_W),
        .STAGES (SYNC_STAGES)
    ) term_sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (term_raw),
        .q_o    (term_sync)
    );

    wrc_seq_fsm fsm_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (req_i),
        .lanes_i   (be_i),
        .ack_s_i   (term_sync[0]),
        .berr_s_i  (term_sync[1]),
        .state_d_o (state_d),
        .load_o    (load),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    wrc_bus_drv #(
        .AW  (AW),
        .DW  (DW),
        .FCW (FCW)
    ) drv_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load),
        .state_d_i (state_d),
        .addr_i    (addr_i),
        .data_i    (wdata_i),
        .fc_i      (fc_i),
        .lanes_i   (be_i),
        .ctl_o     (ctl),
        .fc_o      (fc_o),
        .addr_o    (addr_o),
        .data_o    (data_o)
    );

    assign busy_o    = ctl.busy;
    assign addr_oe_o = ctl.addr_oe;
    assign data_oe_o = ctl.data_oe;
    assign as_no     = ctl.as_n;
    assign rw_o      = ctl.rw;
    assign uds_no    = ctl.uds_n;
    assign lds_no    = ctl.lds_n;

    // R8
    end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (done_o || err_o));

    // R11
    idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!addr_oe_o && !data_oe_o && rw_o && as_no));

endmodule

// File: tb/wrc_write_seq_tb.sv
`timescale 1ns/1ps
module wrc_write_seq_tb_top;

    localparam int AW  = 23;
    localparam int DW  = 16;
    localparam int FCW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [DW-1:0]  wdata = '0;
    logic [FCW-1:0] fc = '0;
    logic [1:0]     be = '0;
    logic           ack_n = 1'b1;
    logic           berr_n = 1'b1;
    logic           busy, done, err, addr_oe, data_oe, as_n, uds_n, lds_n, rw;
    logic [FCW-1:0] fc_out;
    logic [AW-1:0]  addr_out;
    logic [DW-1:0]  data_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wrc_write_seq dut_i (
        .clk_i (clk), .rst_ni (rst_n), .req_i (req), .addr_i (addr),
        .wdata_i (wdata), .fc_i (fc), .be_i (be), .ack_ni (ack_n),
        .berr_ni (berr_n), .busy_o (busy), .done_o (done), .err_o (err),
        .fc_o (fc_out), .addr_o (addr_out), .addr_oe_o (addr_oe),
        .data_o (data_out), .data_oe_o (data_oe), .as_no (as_n),
        .uds_no (uds_n), .lds_no (lds_n), .rw_o (rw)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected control levels for phase index q (0..7 = S0..S7, wait uses 4).
    // Order: busy, addr_oe, data_oe, as_n, rw, uds_n, lds_n.
    function automatic logic [6:0] exp_ctl(input int q, input logic [1:0] m);
        logic s_ph;
        s_ph = (q >= 4) && (q <= 6);
        return {1'b1, q >= 1, q >= 3, !((q >= 2) && (q <= 6)), q < 2,
                !(s_ph && m[1]), !(s_ph && m[0])};
    endfunction

    task automatic idle_checks(input string tag);
        chk(tag, "busy", busy, 0);
        chk(tag, "addr_oe", addr_oe, 0);
        chk(tag, "data_oe", data_oe, 0);
        chk(tag, "as_n", as_n, 1);
        chk(tag, "rw", rw, 1);
        chk(tag, "uds_n/lds_n", {uds_n, lds_n}, 2'b11);
        chk(tag, "fc/addr/data", {fc_out, addr_out, data_out} == '0, 1);
    endtask

    // mode: 0 acknowledge, 1 bus error, 2 both at once.
    task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic [FCW-1:0] f, input logic [1:0] m,
                             input int dly, input int mode, input int inj_p);
        int w, last, q;
        logic [6:0] e;
        w    = (dly + 1) / 2;
        last = 7 + 2 * w;
        @(negedge clk);
        req = 1'b1; addr = a; wdata = d; fc = f; be = m;
        for (int p = 0; p <= last + 1; p++) begin
            @(negedge clk);
            if (p <= last) begin
                q = (p < 5) ? p : ((p < 5 + 2 * w) ? 4 : p - 2 * w);
                e = exp_ctl(q, m);
                chk("R2", "busy", busy, e[6]);
                chk("R3", "addr_oe", addr_oe, e[5]);
                chk("R5", "data_oe", data_oe, e[4]);
                chk("R4", "as_n", as_n, e[3]);
                chk("R4", "rw", rw, e[2]);
                chk("R6", "uds_n", uds_n, e[1]);
                chk("R6", "lds_n", lds_n, e[0]);
                chk("R10", "fc", fc_out, f);
                if (q >= 1) chk("R10", "addr", addr_out, a);
                if (q >= 3) chk("R5", "data", data_out, d);
                chk("R8", "no early end pulse", {done, err}, 2'b00);
            end else begin
                idle_checks("R11");
                chk("R8", "done", done, mode == 0);
                chk("R9", "err", err, mode != 0);
                chk("R7", "length", last + 1, 8 + 2 * ((dly + 1) / 2));
            end
            // request driven while busy must be ignored
            if (p == inj_p) begin
                req = 1'b1; addr = ~a; wdata = ~d; fc = ~f; be = 2'b11;
            end else begin
                req = 1'b0;
            end
            // slave response
            if (p == 2 + dly) begin
                if (mode != 1) ack_n = 1'b0;
                if (mode != 0) berr_n = 1'b0;
            end
            if (p == last) begin
                ack_n = 1'b1; berr_n = 1'b1;
            end
        end
        @(negedge clk);
        chk("R10", "no second cycle", busy, 0);
        chk("R8", "single pulse", {done, err}, 2'b00);
    endtask

    initial begin
        #(20000 * 5);
        n_bad++;
        $display("FAIL R7 watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1977));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_checks("R1");
        chk("R1", "done/err", {done, err}, 2'b00);

        // zero lane mask does not start a cycle (R2)
        req = 1'b1; be = 2'b00; addr = 23'h1234; fc = 3'd5;
        @(negedge clk); req = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk("R2", "zero lanes ignored", busy, 0);
        end

        // directed: boundary delays around sample points (R7)
        run_write(23'h000001, 16'hA55A, 3'd1, 2'b11, 0, 0, -1);
        run_write(23'h7FFFFF, 16'h0F0F, 3'd2, 2'b10, 1, 0, -1);
        run_write(23'h2AAAAA, 16'hFFFF, 3'd5, 2'b01, 2, 0, -1);
        run_write(23'h155555, 16'h1234, 3'd6, 2'b11, 6, 0, -1);
        // bus error, and both together (R9)
        run_write(23'h000ABC, 16'hBEEF, 3'd1, 2'b11, 3, 1, -1);
        run_write(23'h000DEF, 16'hCAFE, 3'd2, 2'b01, 0, 2, -1);
        // request while busy (R10)
        run_write(23'h0F00F0, 16'h5A5A, 3'd3, 2'b10, 4, 0, 3);
        run_write(23'h0F00F1, 16'h6B6B, 3'd4, 2'b11, 0, 0, 7);

        for (int i = 0; i < 40; i++) begin
            logic [1:0] m;
            int dl, md, ij;
            m  = 2'($urandom_range(1, 3));
            dl = $urandom_range(0, 7);
            md = $urandom_range(0, 5);
            md = (md < 4) ? 0 : md - 3;
            ij = $urandom_range(0, 3) == 0 ? $urandom_range(0, 7) : -1;
            run_write(AW'($urandom), DW'($urandom), FCW'($urandom), m, dl, md, ij);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule